// File: doc/BRIEF.md
# Satellite Supply Tone Generator and Source Selector

This block produces the logic-level tone-enable waveform that modulates an antenna supply output with a 22 kHz tone. A free-running oscillator strobe arrives at twenty times the tone rate. A phase counter divides it down to a square wave with equal high and low halves. Two register bits and one external modulation pin then pick where the tone comes from. The tone can be continuous. It can be the internal tone gated on and off by the pin acting as an envelope. Or the pin can carry a finished, already-modulated tone that is forwarded to the output.

In the forwarding mode, a retriggerable burst timer is restarted on every rising edge of the synchronized pin. It forces the output back to idle roughly one tone period after the last rising edge, so a pin that sticks high cannot hold the supply off its nominal level. In the gated mode, the envelope is sampled only at tone-period boundaries, so every emitted pulse is a whole half-period. The block also drives the tone-decoder threshold select, which is the OR of a transmit pin and a register bit. When the supply enable is low, the tone output is held inactive.

Top module: `tone_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first clock edge with `supply_en` high, `tone_out` is 0 (0 = no tone, 1 = tone active).
- R2: The phase counter counts `osc_tick` strobes modulo TONE_DIV (default 20). In continuous mode with `osc_tick` high every cycle, `tone_out` alternates runs of exactly TONE_DIV/2 = 10 cycles high and 10 cycles low. With `osc_tick` held low, the phase freezes and `tone_out` holds its value.
- R3: With `supply_en`=1 and `tone_force`=1, the tone is continuous whatever the values of `ext_pass_sel` and `mod_in`.
- R4: With `tone_force`=0 and `ext_pass_sel`=0, `mod_in` gates the internal tone. The gate is sampled only when the phase counter wraps, so every high pulse of `tone_out` lasts exactly TONE_DIV/2 cycles. A pulse in progress when the envelope drops is completed. With the envelope held low, `tone_out` stays 0.
- R5: With `tone_force`=0 and `ext_pass_sel`=1, `tone_out` equals `mod_in` delayed by exactly 3 clock cycles (two synchronizer flops plus the output register). This holds as long as successive rising edges of `mod_in` are at most TONE_DIV+1 ticks apart.
- R6: In forwarding mode, `tone_out` is forced to 0 once TONE_DIV ticks have passed after the tick that registered the last rising edge. A `mod_in` that rises and stays high gives exactly TONE_DIV+1 = 21 high cycles of `tone_out`. A new rising edge restarts the timer, and it takes precedence over expiry in the same cycle.
- R7: When `supply_en` is 0 at a clock edge, `tone_out` is 0 after that edge, in every mode.
- R8: `thr_high` is 1 when `xmit_pin` or `thresh_bit` is 1, and 0 when both are 0. It has no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator strobe, TONE_DIV per tone period |
| supply_en | input | 1 | Supply enable register bit; 0 holds the tone off |
| tone_force | input | 1 | Continuous tone register bit |
| ext_pass_sel | input | 1 | Forward an external tone (1) or gate the internal one (0) |
| mod_in | input | 1 | Asynchronous external modulation pin |
| xmit_pin | input | 1 | Transmit indication pin for the decoder threshold |
| thresh_bit | input | 1 | Register bit raising the decoder threshold |
| tone_out | output | 1 | Registered tone-enable waveform |
| thr_high | output | 1 | Decoder high-threshold select |

## Verification
In forwarding mode, a rising edge of the synchronized pin can arrive in the same cycle in which the burst timer would expire. Whether the restart or the expiry wins decides if a pulse is lost. The bench provokes this by forwarding a square wave whose rising edges are exactly TONE_DIV+1 ticks apart, so each edge lands on the cycle the timer reaches zero. It also uses a 20-tick wave that restarts the timer one tick early. It judges both waves by comparing `tone_out`, sample by sample, against the pin delayed by three cycles: any dropped or stretched pulse shows as a mismatch. In gated mode, an envelope change that coincides with a period wrap is exercised by an envelope schedule with odd run lengths, and each resulting pulse must still be exactly half a period long.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_CONT  = 2'd1,
    SRC_GATED = 2'd2,
    SRC_PASS  = 2'd3
  } tone_src_e;

  // Source choice: the enable dominates, then the continuous bit, then the pass select.
  function automatic tone_src_e pick_source(input logic en, input logic force_on,
                                            input logic pass_sel);
    if (!en)           return SRC_OFF;
    else if (force_on) return SRC_CONT;
    else if (pass_sel) return SRC_PASS;
    else               return SRC_GATED;
  endfunction

  // The first half of a period is the high half of the tone.
  function automatic logic in_high_half(input int unsigned idx, input int unsigned div);
    return idx < (div / 2);
  endfunction

endpackage

// File: rtl/tone_phase_div.sv
module tone_phase_div #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase_hi,
  output logic period_wrap
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign phase_hi    = tone_pkg::in_high_half(32'(cnt), 32'(DIV));
  assign period_wrap = tick && (cnt == LAST);
endmodule

// File: rtl/tone_in_sync.sv
module tone_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic stg [STAGES+1];
  logic prev;

  assign stg[0] = async_in;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g+1] <= 1'b0;
      else        stg[g+1] <= stg[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= stg[STAGES];
  end

  assign level = stg[STAGES];
  assign rise  = stg[STAGES] & ~prev;
endmodule

// File: rtl/tone_burst_timer.sv
module tone_burst_timer #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic busy
);
  localparam int TW = $clog2(DIV + 1);
  localparam logic [TW-1:0] LOAD = TW'(DIV);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (restart) begin
      left <= LOAD;
    end else if (tick && (left != '0)) begin
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int TONE_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic supply_en,
  input  logic tone_force,
  input  logic ext_pass_sel,
  input  logic mod_in,
  input  logic xmit_pin,
  input  logic thresh_bit,
  output logic tone_out,
  output logic thr_high
);
  import tone_pkg::*;

  // Named internal events, visible to the bound checker.
  logic      phase_hi;
  logic      div_wrap;
  logic      env_level;
  logic      env_rise;
  logic      burst_busy;
  logic      gate_q;
  logic      tone_next;
  tone_src_e src;

  tone_phase_div #(.DIV(TONE_DIV)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (osc_tick),
    .phase_hi    (phase_hi),
    .period_wrap (div_wrap)
  );

  tone_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (mod_in),
    .level    (env_level),
    .rise     (env_rise)
  );

  tone_burst_timer #(.DIV(TONE_DIV)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (osc_tick),
    .restart (env_rise),
    .busy    (burst_busy)
  );

  // The envelope is taken only at a period boundary, so gated pulses are never cut short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (div_wrap) gate_q <= env_level;
  end

  assign src = pick_source(supply_en, tone_force, ext_pass_sel);

  always_comb begin
    unique case (src)
      SRC_CONT:  tone_next = phase_hi;
      SRC_GATED: tone_next = phase_hi & gate_q;
      SRC_PASS:  tone_next = env_level & (burst_busy | env_rise);
      default:   tone_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tone_out <= 1'b0;
    else        tone_out <= tone_next;
  end

  assign thr_high = xmit_pin | thresh_bit;
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                supply_en,
  input tone_pkg::tone_src_e src,
  input logic                div_wrap,
  input logic                phase_hi,
  input logic                gate_q,
  input logic                env_level,
  input logic                env_rise,
  input logic                burst_busy,
  input logic                tone_out
);
  import tone_pkg::*;

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_en |=> !tone_out);

  // R2
  wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wrap |=> phase_hi);

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wrap |=> $stable(gate_q));

  // R4
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_GATED && !gate_q) |=> !tone_out);

  // R3
  cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_CONT && phase_hi) |=> tone_out);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    env_rise |=> burst_busy);

  // R5
  pass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_PASS && !env_level) |=> !tone_out);
endmodule

bind tone_gen tone_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_en  (supply_en),
  .src        (src),
  .div_wrap   (div_wrap),
  .phase_hi   (phase_hi),
  .gate_q     (gate_q),
  .env_level  (env_level),
  .env_rise   (env_rise),
  .burst_busy (burst_busy),
  .tone_out   (tone_out)
);

// File: tb/tb_tone_gen.sv
`timescale 1ns/1ps
module tb_tone_gen;
  localparam int DIV  = 20;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic supply_en = 1'b0;
  logic tone_force = 1'b0;
  logic ext_pass_sel = 1'b0;
  logic mod_in = 1'b0;
  logic xmit_pin = 1'b0;
  logic thresh_bit = 1'b0;
  logic tone_out;
  logic thr_high;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tone_gen dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .supply_en(supply_en),
    .tone_force(tone_force), .ext_pass_sel(ext_pass_sel), .mod_in(mod_in),
    .xmit_pin(xmit_pin), .thresh_bit(thresh_bit), .tone_out(tone_out),
    .thr_high(thr_high)
  );

  typedef struct packed {
    logic       en;
    logic       frc;
    logic       pass;
    logic       env;
    logic       txt;
    logic       tth;
    logic       exp_thr;
    logic [5:0] exp_high;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd20},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd20},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd20},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stimulus changes just after the rising edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic count_high(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      @(negedge clk);
      if (tone_out) cnt++;
    end
  endtask

  function automatic logic env_sched(input int i);
    if (i < 37)  return 1'b1;
    if (i < 60)  return 1'b0;
    if (i < 65)  return 1'b1;
    if (i < 115) return 1'b0;
    if (i < 179) return 1'b1;
    return 1'b0;
  endfunction

  // Forwarding check: tone_out must equal mod_in from three samples back (R5).
  task automatic pass_compare(input int period, input int highs, input int total,
                              output int bad);
    logic hist [3];
    hist[0] = 1'b0; hist[1] = 1'b0; hist[2] = 1'b0;
    bad = 0;
    for (int i = 0; i < total; i++) begin
      logic m;
      m = (i < total - 60) ? ((i % period) < highs) : 1'b0;
      cyc();
      mod_in = m;
      @(negedge clk);
      if (tone_out !== hist[2]) bad++;
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = m;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int cnt;
    int bad;
    int runs;
    int len;
    bit first;
    logic prev;

    // R1: reset holds the output off even with a continuous tone requested.
    supply_en = 1'b1;
    tone_force = 1'b1;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tone_out !== 1'b0) bad++;
    end
    supply_en = 1'b0;
    cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc();
      @(negedge clk);
      if (tone_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R1", bad, 0);

    // Vector table: mode selection and threshold select (R3, R4, R5, R6, R7, R8).
    for (int v = 0; v < NV; v++) begin
      cyc();
      supply_en    = VEC[v].en;
      tone_force   = VEC[v].frc;
      ext_pass_sel = VEC[v].pass;
      mod_in       = VEC[v].env;
      xmit_pin     = VEC[v].txt;
      thresh_bit   = VEC[v].tth;
      #1;
      // R8: combinational threshold select
      chk(thr_high === VEC[v].exp_thr, "R8", int'(thr_high), int'(VEC[v].exp_thr));
      wait_cyc(40);
      count_high(40, cnt);
      chk(cnt == int'(VEC[v].exp_high), "R3 R4 R5 R6 R7 table", cnt,
          int'(VEC[v].exp_high));
    end

    // R2: continuous mode duty, every complete run is HALF cycles long.
    cyc();
    supply_en = 1'b1; tone_force = 1'b1; ext_pass_sel = 1'b0; mod_in = 1'b0;
    wait_cyc(5);
    bad = 0; runs = 0; len = 0; first = 1'b1; prev = 1'bx;
    for (int i = 0; i < 100; i++) begin
      cyc();
      @(negedge clk);
      if (i == 0) begin
        prev = tone_out; len = 1;
      end else if (tone_out !== prev) begin
        if (!first) begin
          runs++;
          if (len != HALF) bad++;
        end
        first = 1'b0; len = 1; prev = tone_out;
      end else begin
        len++;
      end
    end
    chk(bad == 0, "R2 run length", bad, 0);
    chk(runs >= 8, "R2 run count", runs, 8);

    // R2: without oscillator strobes the phase freezes.
    cyc();
    osc_tick = 1'b0;
    cyc();
    @(negedge clk);
    prev = tone_out;
    bad = 0;
    for (int i = 0; i < 15; i++) begin
      cyc();
      @(negedge clk);
      if (tone_out !== prev) bad++;
    end
    chk(bad == 0, "R2 freeze", bad, 0);
    cyc();
    osc_tick = 1'b1;

    // R3: continuous tone ignores a toggling pin with the pass select set.
    ext_pass_sel = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cyc();
      mod_in = ((i % 7) < 3);
    end
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      mod_in = ((i % 7) < 3);
      @(negedge clk);
      if (tone_out) cnt++;
    end
    chk(cnt == HALF * 2, "R3", cnt, HALF * 2);

    // R4: gated mode, whole half-period pulses only.
    cyc();
    tone_force = 1'b0; ext_pass_sel = 1'b0; mod_in = 1'b0;
    wait_cyc(45);
    bad = 0; runs = 0; len = 0;
    for (int i = 0; i < 240; i++) begin
      cyc();
      mod_in = env_sched(i);
      @(negedge clk);
      if (tone_out) begin
        len++;
      end else if (len != 0) begin
        runs++;
        if (len != HALF) bad++;
        len = 0;
      end
    end
    chk(bad == 0 && len == 0, "R4 pulse width", bad + len, 0);
    chk(runs >= 4, "R4 pulse count", runs, 4);

    // R5/R6: forwarding with edges 20 ticks apart, then 21 (restart meets expiry).
    cyc();
    mod_in = 1'b0; ext_pass_sel = 1'b1;
    wait_cyc(40);
    pass_compare(DIV, HALF, 240, bad);
    chk(bad == 0, "R5 period 20", bad, 0);
    pass_compare(DIV + 1, HALF, 250, bad);
    chk(bad == 0, "R6 period 21 restart", bad, 0);

    // R6: stuck-high pin ends the burst after TONE_DIV+1 cycles.
    cyc();
    mod_in = 1'b1;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      cyc();
      @(negedge clk);
      if (tone_out) cnt++;
    end
    chk(cnt == DIV + 1, "R6 stuck high", cnt, DIV + 1);
    cyc();
    mod_in = 1'b0;
    wait_cyc(10);

    // R7: dropping the enable mid-pulse silences the output from the next edge.
    ext_pass_sel = 1'b0; tone_force = 1'b1;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      @(negedge clk);
      if (tone_out) break;
    end
    cyc();
    supply_en = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cyc();
      @(negedge clk);
      if (tone_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R7", bad, 0);

    // R8: threshold select responds without a clock edge.
    xmit_pin = 1'b0; thresh_bit = 1'b0;
    #1;
    chk(thr_high === 1'b0, "R8 both low", int'(thr_high), 0);
    xmit_pin = 1'b1;
    #1;
    chk(thr_high === 1'b1, "R8 pin only", int'(thr_high), 1);

    report();
  end
endmodule